// File: doc/BRIEF.md
# Page Write Buffer with Timed Commit

This block sits behind a serial slave in a small byte-addressed nonvolatile store. It collects the data bytes of one write transfer into a 16-entry page buffer. When the transfer is closed, it runs a self-timed write cycle that copies the collected bytes into a 256 x 8 array through a simple write port. A load-address strobe sets the word pointer. Each data-byte strobe stores one byte at the slot chosen by the pointer's low four bits and then advances those bits. A stop strobe starts the commit when at least one byte is waiting.

During the commit, `busy` stays high for a fixed number of system clocks, set by a parameter. The buffered bytes reach the array one per clock at the start of that window, in ascending slot order. The rest of the window is idle timer time. The write-protect and supply-ok inputs are sampled at the stop. They can turn the cycle into one that takes the full time but changes nothing.

Top module: `page_commit`

## Requirements
- R1: After reset, `busy` and `arr_we` are low, and no write cycle starts until a stop follows a data byte.
- R2: A data byte is stored at slot = low 4 bits of the word pointer, and those bits then increment. The upper 4 bits set by the address load stay fixed, and the byte reaches array address {upper 4 bits, slot}.
- R3: When more than 16 bytes arrive, the slot index wraps to slot 0 of the same page. A later byte replaces the earlier byte held in the same slot, and no address outside the page is written.
- R4: A stop with no buffered byte starts no cycle. A new address load before the stop (a repeated start) discards the bytes buffered so far.
- R5: After an accepted stop, `busy` rises on the next clock and stays high for exactly CYCLE_CLKS clocks.
- R6: Only the slots loaded in the transfer are written. The other bytes of the page keep their contents. The writes occur one per clock, in ascending slot order, while `busy` is high.
- R7: With write-protect high at the stop, a page whose address bit 7 is 1 (8'h80 to 8'hFF) receives no write, yet `busy` lasts the full CYCLE_CLKS. Pages in the lower half are still written.
- R8: With write-protect low at the stop, pages in the upper half are written normally.
- R9: With supply-ok low at the stop, the cycle runs its full length and writes nothing.
- R10: Write-protect and supply-ok are held from their values at the stop. Changing them while `busy` is high has no effect on that cycle.
- R11: Address, data and stop strobes that arrive while `busy` is high are ignored. The loaded-slot mask is cleared when the cycle ends, so a later stop with no new byte starts no cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr_ld | input | 1 | Strobe: load the word pointer and start a fresh buffer |
| addr_in | input | 8 | Word address loaded by `addr_ld` |
| byte_ld | input | 1 | Strobe: store one data byte |
| byte_in | input | 8 | Data byte stored by `byte_ld` |
| stop_in | input | 1 | Strobe: the transfer ended with a stop |
| wp_in | input | 1 | Write-protect for the upper half of the array |
| pwr_ok | input | 1 | Supply good; low blocks all array writes |
| busy | output | 1 | Write cycle in progress |
| arr_we | output | 1 | Array write enable, one byte per clock |
| arr_addr | output | 8 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The checker watches some rules on every clock:
- every array write falls inside a busy window and is allowed by the held protect and supply samples;
- each window opens only after a stop;
- the page bits and held samples stay constant through the window;
- successive writes step up by one slot;
- every window lasts exactly CYCLE_CLKS.

Other rules can only be shown by the directed scenarios against a reference copy of the array:
- which bytes end up where after a pointer wrap;
- that unloaded slots and neighbouring pages keep their contents;
- that a repeated start discards earlier bytes;
- that strobes made during busy leave no trace once the cycle ends.

// File: rtl/page_commit_pkg.sv
package page_commit_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_DRAIN = 2'd1,
    CYC_HOLD  = 2'd2
  } cyc_state_t;
endpackage

// File: rtl/page_ptr.sv
// Word pointer: upper part fixed by an address load, lower part steps per byte
// and wraps inside the page.
module page_ptr #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_en,
  input  logic [ADDR_W-1:0]       load_val,
  input  logic                    step_en,
  output logic [ADDR_W-IDX_W-1:0] page_base,
  output logic [IDX_W-1:0]        slot
);
  localparam int PAGE_W = ADDR_W - IDX_W;

  logic [PAGE_W-1:0] base_d, base_q;
  logic [IDX_W-1:0]  slot_d, slot_q;

  always_comb begin
    base_d = base_q;
    slot_d = slot_q;
    if (load_en) begin
      base_d = load_val[ADDR_W-1:IDX_W];
      slot_d = load_val[IDX_W-1:0];
    end else if (step_en) begin
      slot_d = slot_q + 1'b1;  // natural wrap within the page
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      slot_q <= '0;
    end else begin
      base_q <= base_d;
      slot_q <= slot_d;
    end
  end

  assign page_base = base_q;
  assign slot      = slot_q;
endmodule

// File: rtl/page_buf.sv
// Page buffer: one data register and one loaded flag per slot.
module page_buf #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              any_valid
);
  localparam int SLOTS = 1 << IDX_W;

  logic [DATA_W-1:0] data_q [SLOTS];
  logic [SLOTS-1:0]  vld_d, vld_q;

  for (genvar g = 0; g < SLOTS; g++) begin : g_slot
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));

    // Data storage carries no reset; the loaded flag qualifies it.
    always_ff @(posedge clk) begin
      if (hit) data_q[g] <= wr_data;
    end

    always_comb begin
      vld_d[g] = vld_q[g];
      if (clr)      vld_d[g] = 1'b0;
      else if (hit) vld_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  assign rd_data   = data_q[rd_idx];
  assign rd_valid  = vld_q[rd_idx];
  assign any_valid = |vld_q;
endmodule

// File: rtl/commit_seq.sv
// Write-cycle sequencer: scans all slots one per clock, then runs out the timer.
module commit_seq
  import page_commit_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int CYC    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             stop_in,
  input  logic             any_valid,
  input  logic             wp_in,
  input  logic             pwr_ok,
  output logic             busy,
  output logic             drain_act,
  output logic [IDX_W-1:0] drain_idx,
  output logic             wp_hold,
  output logic             ok_hold,
  output logic             cycle_done
);
  localparam int CNT_W = $clog2(CYC + 1);
  localparam logic [IDX_W-1:0] LAST_IDX = {IDX_W{1'b1}};

  cyc_state_t       st_d, st_q;
  logic [CNT_W-1:0] cnt_d, cnt_q;
  logic [IDX_W-1:0] idx_d, idx_q;
  logic             wp_d, wp_q, ok_d, ok_q;

  always_comb begin
    st_d       = st_q;
    cnt_d      = cnt_q;
    idx_d      = idx_q;
    wp_d       = wp_q;
    ok_d       = ok_q;
    cycle_done = 1'b0;
    case (st_q)
      CYC_IDLE: begin
        if (stop_in && any_valid) begin
          st_d  = CYC_DRAIN;
          cnt_d = CNT_W'(CYC - 1);
          idx_d = '0;
          wp_d  = wp_in;
          ok_d  = pwr_ok;
        end
      end
      CYC_DRAIN, CYC_HOLD: begin
        if (cnt_q == '0) begin
          st_d       = CYC_IDLE;
          cycle_done = 1'b1;
        end else begin
          cnt_d = cnt_q - 1'b1;
          if (st_q == CYC_DRAIN) begin
            if (idx_q == LAST_IDX) st_d = CYC_HOLD;
            else                   idx_d = idx_q + 1'b1;
          end
        end
      end
      default: st_d = CYC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= CYC_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      wp_q  <= 1'b0;
      ok_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      wp_q  <= wp_d;
      ok_q  <= ok_d;
    end
  end

  assign busy      = (st_q != CYC_IDLE);
  assign drain_act = (st_q == CYC_DRAIN);
  assign drain_idx = idx_q;
  assign wp_hold   = wp_q;
  assign ok_hold   = ok_q;
endmodule

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int IDX_W      = 4,
  parameter int CYCLE_CLKS = 200000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_ld,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              byte_ld,
  input  logic [DATA_W-1:0] byte_in,
  input  logic              stop_in,
  input  logic              wp_in,
  input  logic              pwr_ok,
  output logic              busy,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_wdata
);
  localparam int SLOTS   = 1 << IDX_W;
  localparam int PAGE_W  = ADDR_W - IDX_W;
  // The scan of every slot must fit inside the busy window.
  localparam int CYC_EFF = (CYCLE_CLKS < SLOTS) ? SLOTS : CYCLE_CLKS;

  logic [PAGE_W-1:0] page_base;
  logic [IDX_W-1:0]  slot;
  logic [IDX_W-1:0]  drain_idx;
  logic [DATA_W-1:0] rd_data;
  logic              rd_valid, any_valid;
  logic              drain_act, wp_hold, ok_hold, cycle_done;
  logic              take_addr, take_byte, allow_wr;

  assign take_addr = addr_ld && !busy;
  assign take_byte = byte_ld && !busy && !addr_ld;

  page_ptr #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (take_addr),
    .load_val  (addr_in),
    .step_en   (take_byte),
    .page_base (page_base),
    .slot      (slot)
  );

  page_buf #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (take_byte),
    .wr_idx    (slot),
    .wr_data   (byte_in),
    .clr       (cycle_done || take_addr),
    .rd_idx    (drain_idx),
    .rd_data   (rd_data),
    .rd_valid  (rd_valid),
    .any_valid (any_valid)
  );

  commit_seq #(.IDX_W(IDX_W), .CYC(CYC_EFF)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_in    (stop_in),
    .any_valid  (any_valid),
    .wp_in      (wp_in),
    .pwr_ok     (pwr_ok),
    .busy       (busy),
    .drain_act  (drain_act),
    .drain_idx  (drain_idx),
    .wp_hold    (wp_hold),
    .ok_hold    (ok_hold),
    .cycle_done (cycle_done)
  );

  // Upper half of the array is the protected region: page MSB set.
  assign allow_wr  = ok_hold && !(wp_hold && page_base[PAGE_W-1]);
  assign arr_we    = drain_act && rd_valid && allow_wr;
  assign arr_addr  = {page_base, drain_idx};
  assign arr_wdata = rd_data;
endmodule

// File: rtl/page_commit_chk.sv
module page_commit_chk #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 4,
  parameter int CYC    = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stop_in,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_addr,
  input logic              wp_hold,
  input logic              ok_hold
);
  logic [31:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    run_q <= '0;
    else if (busy) run_q <= run_q + 1'b1;
    else           run_q <= '0;
  end

  p_idle_after_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !arr_we);
  p_write_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> busy);
  p_ascending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we && $past(arr_we) && $past(busy) |->
      arr_addr[IDX_W-1:0] == $past(arr_addr[IDX_W-1:0]) + 1'b1);
  p_start_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_in));
  p_window_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_q == 32'(CYC));
  p_protect_r7: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> !(wp_hold && arr_addr[ADDR_W-1]));
  p_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
    arr_we |-> ok_hold);
  p_hold_samples_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(wp_hold) && $stable(ok_hold));
  p_page_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    busy && $past(busy) |-> $stable(arr_addr[ADDR_W-1:IDX_W]));
endmodule

bind page_commit page_commit_chk #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .CYC(CYC_EFF)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .stop_in  (stop_in),
  .arr_we   (arr_we),
  .arr_addr (arr_addr),
  .wp_hold  (wp_hold),
  .ok_hold  (ok_hold)
);

// File: tb/sim_page_commit.sv
`timescale 1ns/1ps
module sim_page_commit;
  localparam int CYC = 40;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       addr_ld = 1'b0, byte_ld = 1'b0, stop_in = 1'b0;
  logic [7:0] addr_in = '0, byte_in = '0;
  logic       wp_in = 1'b0, pwr_ok = 1'b1;
  logic       busy, arr_we;
  logic [7:0] arr_addr, arr_wdata;

  int checks = 0;
  int errors = 0;

  logic [7:0] arr_mem [256];
  logic [7:0] ref_mem [256];
  logic [7:0] wlog [256];
  int         wcnt = 0;
  int         run = 0;
  int         last_run = 0;

  always #2.5 clk = ~clk;

  page_commit #(.CYCLE_CLKS(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_ld(addr_ld), .addr_in(addr_in),
    .byte_ld(byte_ld), .byte_in(byte_in), .stop_in(stop_in),
    .wp_in(wp_in), .pwr_ok(pwr_ok), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  // Array model and busy-window meter
  always @(posedge clk) begin
    if (arr_we) begin
      arr_mem[arr_addr] <= arr_wdata;
      wlog[wcnt[7:0]]   <= arr_addr;
      wcnt              <= wcnt + 1;
    end
    if (busy) run <= run + 1;
    else begin
      if (run != 0) last_run <= run;
      run <= 0;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_page(input string req, input int base);
    int bad = -1;
    for (int i = 0; i < 16; i++)
      if (bad < 0 && arr_mem[base+i] != ref_mem[base+i]) bad = i;
    checks++;
    if (bad >= 0) begin
      errors++;
      $display("FAIL %s addr=%0d actual=%0d expected=%0d", req, base+bad,
               arr_mem[base+bad], ref_mem[base+bad]);
    end
  endtask

  task automatic pulse_addr(input logic [7:0] a);
    addr_in = a; addr_ld = 1'b1; @(negedge clk); addr_ld = 1'b0;
  endtask
  task automatic pulse_byte(input logic [7:0] d);
    byte_in = d; byte_ld = 1'b1; @(negedge clk); byte_ld = 1'b0;
  endtask
  task automatic pulse_stop();
    stop_in = 1'b1; @(negedge clk); stop_in = 1'b0;
  endtask
  task automatic wait_idle();
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask
  task automatic quiet_check(input string req);
    int seen = 0;
    repeat (5) begin @(negedge clk); if (busy) seen = 1; end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 busy after reset", busy, 0);
    check("R1 arr_we after reset", arr_we, 0);
    pulse_stop();
    quiet_check("R1 stop without data");
  endtask

  task automatic t_single();
    int w0 = wcnt;
    pulse_addr(8'h23); pulse_byte(8'hA5); pulse_stop();
    check("R5 busy right after stop", busy, 1);
    wait_idle();
    ref_mem[8'h23] = 8'hA5;
    check("R5 busy length", last_run, CYC);
    check("R2 single write count", wcnt - w0, 1);
    check_page("R2 single byte page", 8'h20);
  endtask

  task automatic t_partial();
    int w0 = wcnt;
    pulse_addr(8'h35);
    for (int k = 0; k < 3; k++) begin
      pulse_byte(8'(8'h60 + k)); ref_mem[8'h35 + k] = 8'(8'h60 + k);
    end
    pulse_stop(); wait_idle();
    check("R6 partial write count", wcnt - w0, 3);
    check("R6 order first", wlog[w0[7:0]], 8'h35);
    check("R6 order last", wlog[8'(w0 + 2)], 8'h37);
    check_page("R6 untouched slots", 8'h30);
  endtask

  task automatic t_wrap();
    int w0 = wcnt;
    pulse_addr(8'h4E);
    for (int k = 0; k < 18; k++) begin
      pulse_byte(8'(8'hC0 + k));
      ref_mem[8'h40 + ((14 + k) % 16)] = 8'(8'hC0 + k);
    end
    pulse_stop(); wait_idle();
    check("R3 wrap write count", wcnt - w0, 16);
    check_page("R3 wrapped page", 8'h40);
    check_page("R3 next page untouched", 8'h50);
  endtask

  task automatic t_nodata();
    pulse_addr(8'h66); pulse_stop();
    quiet_check("R4 address-only transfer");
    pulse_addr(8'h60); pulse_byte(8'h11);
    pulse_addr(8'h62); pulse_byte(8'h22);
    pulse_stop(); wait_idle();
    ref_mem[8'h62] = 8'h22;
    check_page("R4 repeated start discards", 8'h60);
  endtask

  task automatic t_protect();
    int w0 = wcnt;
    wp_in = 1'b1;
    pulse_addr(8'h90); pulse_byte(8'h77); pulse_stop(); wait_idle();
    check("R7 protected busy length", last_run, CYC);
    check("R7 protected write count", wcnt - w0, 0);
    check_page("R7 protected page", 8'h90);
    pulse_addr(8'h10); pulse_byte(8'h78); pulse_stop(); wait_idle();
    ref_mem[8'h10] = 8'h78;
    check_page("R7 lower half writable", 8'h10);
    wp_in = 1'b0;
    pulse_addr(8'hF0); pulse_byte(8'h79); pulse_byte(8'h7A); pulse_stop(); wait_idle();
    ref_mem[8'hF0] = 8'h79; ref_mem[8'hF1] = 8'h7A;
    check_page("R8 upper half writable", 8'hF0);
  endtask

  task automatic t_supply();
    int w0 = wcnt;
    pwr_ok = 1'b0;
    pulse_addr(8'h20); pulse_byte(8'h5C); pulse_stop(); wait_idle();
    pwr_ok = 1'b1;
    check("R9 no-supply busy length", last_run, CYC);
    check("R9 no-supply write count", wcnt - w0, 0);
    check_page("R9 no-supply page", 8'h20);
  endtask

  task automatic t_sampled();
    pulse_addr(8'hA0); pulse_byte(8'h3D); pulse_stop();
    wp_in = 1'b1; wait_idle(); wp_in = 1'b0;
    ref_mem[8'hA0] = 8'h3D;
    check_page("R10 late write-protect ignored", 8'hA0);
    pwr_ok = 1'b0;
    pulse_addr(8'hB0); pulse_byte(8'h3E); pulse_stop();
    pwr_ok = 1'b1; wait_idle();
    check_page("R10 late supply recovery ignored", 8'hB0);
  endtask

  task automatic t_busy_strobes();
    pulse_addr(8'h70); pulse_byte(8'h01); pulse_stop();
    pulse_addr(8'h7F); pulse_byte(8'hEE); pulse_stop();
    wait_idle();
    ref_mem[8'h70] = 8'h01;
    check("R11 busy length with strobes", last_run, CYC);
    check_page("R11 strobes while busy", 8'h70);
    pulse_stop();
    quiet_check("R11 mask cleared at end");
  endtask

  initial begin
    for (int i = 0; i < 256; i++) begin
      arr_mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_partial();
    t_wrap();
    t_nodata();
    t_protect();
    t_supply();
    t_sampled();
    t_busy_strobes();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule